// File: doc/BRIEF.md
# Potentiometer Command Execution Engine

This block sits behind a two-wire serial slave front end and carries out the commands sent to a bank of digitally set potentiometers. The front end handles the bus bits and hands over event pulses: a start condition, a stop condition, a complete instruction byte, a complete data byte, and a single wiper step with its direction. The engine keeps one 8-bit wiper register per channel and a file of stored data registers, several per channel. It decodes each instruction and executes it. It tells the front end whether a third byte belongs to the command and whether stepping mode is active. For read commands it presents the byte to be shifted out.

A command collects its operands until the stop condition and takes effect only there. A new start condition before the stop cancels it. Any command that changes a stored data register stands for a slow nonvolatile write. From the cycle after the stop, the engine reports busy for a fixed number of clock cycles. While busy it ignores new instructions, so the front end can refuse to acknowledge. The bits of a wiper register below position width form the tap position. The two bits above it are carried unchanged. Stepping changes only the position and saturates at both ends.

Top module: `pot_cmd_engine`

## Requirements
- R1: After a synchronous active-low reset, every wiper and stored register is zero, `busy`, `data_phase` and `step_mode` are low, and `rd_data` is zero.
- R2: In the instruction byte, bits 7:4 are the opcode, bits 3:2 select the channel and bits 1:0 select the stored register within that channel.
- R3: Opcode 1001 loads `rd_data` with the selected channel's wiper, ignoring bits 1:0. Opcode 1011 loads it with the selected stored register. In both cases the value is visible the cycle after `instr_valid`.
- R4: Opcode 1010 followed by a data byte writes that byte to the selected wiper in the cycle after the stop. With no data byte, or without a stop, the wiper is unchanged.
- R5: Opcode 1100 followed by a data byte writes that byte to the selected stored register at the stop and starts a nonvolatile busy window.
- R6: At the stop, opcode 1101 copies the selected stored register to its channel's wiper. Opcode 1110 copies the channel's wiper to the selected stored register and starts a busy window.
- R7: At the stop, opcode 0001 copies stored register bits 1:0 of every channel to that channel's wiper. Opcode 1000 copies every wiper to stored register bits 1:0 of its own channel and starts a busy window. Both ignore bits 3:2.
- R8: Opcode 0010 enables stepping of the selected wiper. Each step pulse with `step_up`=1 raises the low 6-bit position by one, saturating at 63. With `step_up`=0 it lowers the position by one, saturating at 0. Bits 7:6 are kept, and the new value shows the cycle after the pulse. Step pulses outside stepping mode have no effect.
- R9: From the cycle after the instruction until the command ends, `data_phase` is high for opcodes 1001, 1010, 1011 and 1100, and `step_mode` is high for opcode 0010. Both are low for every other opcode.
- R10: `busy` rises the cycle after a stop that commits a stored-register write and stays high for exactly BUSY_CYCLES cycles. Instructions arriving while it is high are ignored.
- R11: The opcodes 0000, 0011 to 0111 and 1111 change no register, raise neither phase flag and start no busy window.
- R12: A start condition before the stop discards the pending command without any register change or busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_det | input | 1 | Start condition seen (one-cycle pulse) |
| stop_det | input | 1 | Stop condition seen (one-cycle pulse) |
| instr_valid | input | 1 | Instruction byte complete (pulse) |
| instr_byte | input | 8 | Instruction byte: opcode, channel select, register select |
| data_valid | input | 1 | Third byte complete (pulse) |
| data_byte | input | DW | Received third byte |
| step_valid | input | 1 | One step clock in stepping mode (pulse) |
| step_up | input | 1 | Step direction: 1 towards the top end, 0 towards the bottom |
| data_phase | output | 1 | Pending command carries a third byte |
| step_mode | output | 1 | Pending command is stepping |
| busy | output | 1 | Nonvolatile write in progress |
| rd_data | output | DW | Byte to shift out for a read command |
| wiper_bus | output | NUM_CH*DW | All wiper registers, channel 0 in the low byte |

## Verification
Every result of this engine is registered once. Read data and the two phase flags change one cycle after the instruction pulse. Wiper and stored-register changes appear one cycle after the stop pulse, or after the step pulse in stepping mode. `busy` rises one cycle after the committing stop and falls BUSY_CYCLES cycles later. The bench drives each event pulse for a single cycle between falling edges and samples the outputs at the next falling edge, after exactly one rising edge. It also compares every output with a behavioural model on every falling edge. The busy window is measured by counting falling edges with `busy` high.

// File: rtl/potcmd_pkg.sv
// Package: opcode codes and the decoded-command record shared by the
// command engine and its decoder. Assumes a 4-bit opcode field.
package potcmd_pkg;

    localparam logic [3:0] OP_GLOAD  = 4'b0001;
    localparam logic [3:0] OP_STEP   = 4'b0010;
    localparam logic [3:0] OP_GSTORE = 4'b1000;
    localparam logic [3:0] OP_RD_W   = 4'b1001;
    localparam logic [3:0] OP_WR_W   = 4'b1010;
    localparam logic [3:0] OP_RD_R   = 4'b1011;
    localparam logic [3:0] OP_WR_R   = 4'b1100;
    localparam logic [3:0] OP_LOAD   = 4'b1101;
    localparam logic [3:0] OP_STORE  = 4'b1110;

    // Execution-relevant view of a command, held until it ends.
    typedef struct packed {
        logic wr_wiper;   // host byte -> wiper
        logic wr_reg;     // host byte -> stored register
        logic load_one;   // stored register -> wiper, one channel
        logic store_one;  // wiper -> stored register, one channel
        logic load_all;   // stored register -> wiper, every channel
        logic store_all;  // wiper -> stored register, every channel
        logic step;       // stepping mode
        logic third;      // command carries a third byte
    } cmd_dec_t;

endpackage

// File: rtl/pot_cmd_decode.sv
// Opcode decoder: turns the 4-bit opcode into the execution record plus
// the two read flags, which are only needed in the instruction cycle.
// Assumes undefined opcodes decode to all zeros (no operation).
module pot_cmd_decode
    import potcmd_pkg::*;
(
    input  logic [3:0] opcode,
    output cmd_dec_t   dec,
    output logic       rd_wiper,
    output logic       rd_reg
);

    // Purpose: map each defined opcode to its operation flags.
    always_comb begin
        dec      = '0;
        rd_wiper = 1'b0;
        rd_reg   = 1'b0;
        unique case (opcode)
            OP_RD_W:   begin rd_wiper = 1'b1; dec.third = 1'b1; end
            OP_RD_R:   begin rd_reg   = 1'b1; dec.third = 1'b1; end
            OP_WR_W:   begin dec.wr_wiper = 1'b1; dec.third = 1'b1; end
            OP_WR_R:   begin dec.wr_reg   = 1'b1; dec.third = 1'b1; end
            OP_LOAD:   dec.load_one  = 1'b1;
            OP_STORE:  dec.store_one = 1'b1;
            OP_GLOAD:  dec.load_all  = 1'b1;
            OP_GSTORE: dec.store_all = 1'b1;
            OP_STEP:   dec.step      = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/pot_busy_timer.sv
// Nonvolatile write timer: a load pulse starts a window of BUSY_CYCLES
// clock cycles during which busy is high. Assumes BUSY_CYCLES >= 1.
module pot_busy_timer #(
    parameter int BUSY_CYCLES = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: reload on a committed write, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(BUSY_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

    // R10: a committed write always opens the window.
    p_load_opens_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);

    // R10: once idle, busy stays low without a new load.
    p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !busy) |=> !busy);

endmodule

// File: rtl/pot_step_sat.sv
// Saturating one-tap step of a wiper value: changes only the low POS_W
// bits, keeps the control bits above them. Assumes DW > POS_W.
module pot_step_sat #(
    parameter int DW    = 8,
    parameter int POS_W = 6
) (
    input  logic [DW-1:0] cur,
    input  logic          up,
    output logic [DW-1:0] nxt
);

    localparam logic [POS_W-1:0] POS_MAX = '1;

    logic [POS_W-1:0] pos;

    // Purpose: move the position one tap, clamped at both ends.
    always_comb begin
        pos = cur[POS_W-1:0];
        if (up && pos != POS_MAX) begin
            pos = pos + POS_W'(1);
        end else if (!up && pos != '0) begin
            pos = pos - POS_W'(1);
        end
        nxt = {cur[DW-1:POS_W], pos};
    end

endmodule

// File: rtl/pot_regfile.sv
// Wiper and stored-register storage: NUM_CH wipers and NUM_CH*NUM_REG
// stored registers, each with its own write enable. Stored register e
// belongs to channel e / NUM_REG. Assumes writes are decided upstream.
module pot_regfile #(
    parameter int NUM_CH  = 4,
    parameter int NUM_REG = 4,
    parameter int DW      = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_CH-1:0]                  wiper_we,
    input  logic [NUM_CH-1:0][DW-1:0]          wiper_wd,
    input  logic [NUM_CH*NUM_REG-1:0]          reg_we,
    input  logic [NUM_CH*NUM_REG-1:0][DW-1:0]  reg_wd,
    output logic [NUM_CH-1:0][DW-1:0]          wiper_q,
    output logic [NUM_CH*NUM_REG-1:0][DW-1:0]  reg_q
);

    localparam int NREG = NUM_CH * NUM_REG;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_wiper
        // Purpose: hold one wiper, loading it when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wiper_q[g] <= '0;
            end else if (wiper_we[g]) begin
                wiper_q[g] <= wiper_wd[g];
            end
        end
    end

    for (genvar e = 0; e < NREG; e++) begin : g_store
        // Purpose: hold one stored register, loading it when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reg_q[e] <= '0;
            end else if (reg_we[e]) begin
                reg_q[e] <= reg_wd[e];
            end
        end
    end

    // R11: without any enable from the engine no stored value moves.
    p_store_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we == '0) |=> $stable(reg_q));

endmodule

// File: rtl/pot_cmd_engine.sv
// Command execution engine for a bank of digitally set potentiometers.
// Takes event pulses from a serial slave front end, holds the pending
// command until the stop, then commits it. Stored-register writes start
// the nonvolatile busy window. Assumes one event class per cycle is the
// norm; if several coincide, priority is start, stop, instruction, data,
// step. Assumes NUM_CH and NUM_REG are powers of two filling bits 3:0.
module pot_cmd_engine
    import potcmd_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int NUM_REG     = 4,
    parameter int DW          = 8,
    parameter int POS_W       = 6,
    parameter int BUSY_CYCLES = 2_000_000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_det,
    input  logic                 stop_det,
    input  logic                 instr_valid,
    input  logic [7:0]           instr_byte,
    input  logic                 data_valid,
    input  logic [DW-1:0]        data_byte,
    input  logic                 step_valid,
    input  logic                 step_up,
    output logic                 data_phase,
    output logic                 step_mode,
    output logic                 busy,
    output logic [DW-1:0]        rd_data,
    output logic [NUM_CH*DW-1:0] wiper_bus
);

    localparam int CH_W = $clog2(NUM_CH);
    localparam int RS_W = $clog2(NUM_REG);
    localparam int NREG = NUM_CH * NUM_REG;

    // Fields of the incoming instruction.
    logic [3:0]      in_op;
    logic [CH_W-1:0] in_ch;
    logic [RS_W-1:0] in_rs;
    assign in_op = instr_byte[7:4];
    assign in_ch = instr_byte[RS_W +: CH_W];
    assign in_rs = instr_byte[RS_W-1:0];

    // Pending command state.
    logic            active_q;
    logic            got_q;
    cmd_dec_t        dec_q;
    logic [CH_W-1:0] ch_q;
    logic [RS_W-1:0] rs_q;
    logic [DW-1:0]   data_q;
    logic [DW-1:0]   rd_q;

    cmd_dec_t dec_in;
    logic     in_rd_wiper;
    logic     in_rd_reg;

    pot_cmd_decode u_decode (
        .opcode   (in_op),
        .dec      (dec_in),
        .rd_wiper (in_rd_wiper),
        .rd_reg   (in_rd_reg)
    );

    // Storage.
    logic [NUM_CH-1:0]          wiper_we;
    logic [NUM_CH-1:0][DW-1:0]  wiper_wd;
    logic [NREG-1:0]            reg_we;
    logic [NREG-1:0][DW-1:0]    reg_wd;
    logic [NUM_CH-1:0][DW-1:0]  wiper_q;
    logic [NREG-1:0][DW-1:0]    reg_q;

    pot_regfile #(
        .NUM_CH  (NUM_CH),
        .NUM_REG (NUM_REG),
        .DW      (DW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wiper_we (wiper_we),
        .wiper_wd (wiper_wd),
        .reg_we   (reg_we),
        .reg_wd   (reg_wd),
        .wiper_q  (wiper_q),
        .reg_q    (reg_q)
    );

    // Event qualification in priority order.
    logic ev_start, ev_stop, ev_instr, ev_data, ev_step, commit, nv_load;
    assign ev_start = start_det;
    assign ev_stop  = !start_det && stop_det;
    assign ev_instr = !start_det && !stop_det && instr_valid && !busy;
    assign ev_data  = !start_det && !stop_det && !instr_valid && data_valid
                      && active_q && (dec_q.wr_wiper || dec_q.wr_reg);
    assign ev_step  = !start_det && !stop_det && !instr_valid && step_valid
                      && active_q && dec_q.step;
    assign commit   = ev_stop && active_q;
    assign nv_load  = commit && ((dec_q.wr_reg && got_q)
                                 || dec_q.store_one || dec_q.store_all);

    pot_busy_timer #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (nv_load),
        .busy  (busy)
    );

    logic [DW-1:0] step_val;

    pot_step_sat #(
        .DW    (DW),
        .POS_W (POS_W)
    ) u_step (
        .cur (wiper_q[ch_q]),
        .up  (step_up),
        .nxt (step_val)
    );

    // Per-channel wiper write decision.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_wsel
        localparam logic [CH_W-1:0] CH = CH_W'(g);
        logic hit;
        assign hit = (ch_q == CH);
        assign wiper_we[g] = (ev_step && hit)
            || (commit && (((dec_q.wr_wiper && got_q) || dec_q.load_one) && hit
                           || dec_q.load_all));
        assign wiper_wd[g] = ev_step        ? step_val :
                             dec_q.wr_wiper ? data_q   : reg_q[{CH, rs_q}];
    end

    // Per-entry stored-register write decision.
    for (genvar e = 0; e < NREG; e++) begin : g_rsel
        localparam logic [CH_W-1:0] CH = CH_W'(e / NUM_REG);
        localparam logic [RS_W-1:0] RS = RS_W'(e % NUM_REG);
        assign reg_we[e] = commit && (rs_q == RS)
            && ((((dec_q.wr_reg && got_q) || dec_q.store_one) && ch_q == CH)
                || dec_q.store_all);
        assign reg_wd[e] = dec_q.wr_reg ? data_q : wiper_q[e / NUM_REG];
    end

    // Purpose: track the pending command through its bus events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            got_q    <= 1'b0;
            dec_q    <= '0;
            ch_q     <= '0;
            rs_q     <= '0;
            data_q   <= '0;
        end else if (ev_start || ev_stop) begin
            active_q <= 1'b0;
            got_q    <= 1'b0;
        end else if (ev_instr) begin
            active_q <= 1'b1;
            got_q    <= 1'b0;
            dec_q    <= dec_in;
            ch_q     <= in_ch;
            rs_q     <= in_rs;
        end else if (ev_data) begin
            got_q    <= 1'b1;
            data_q   <= data_byte;
        end
    end

    // Purpose: capture the byte a read command will shift out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (ev_instr && in_rd_wiper) begin
            rd_q <= wiper_q[in_ch];
        end else if (ev_instr && in_rd_reg) begin
            rd_q <= reg_q[{in_ch, in_rs}];
        end
    end

    assign data_phase = active_q && dec_q.third;
    assign step_mode  = active_q && dec_q.step;
    assign rd_data    = rd_q;
    assign wiper_bus  = wiper_q;

    // R9: a command is never both a three-byte and a stepping command.
    p_phase_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_phase && step_mode));

    // R10: no command can be pending while the write window is open.
    p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!data_phase && !step_mode));

    // R4: wipers move only on a committing stop or an accepted step.
    p_wiper_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(stop_det && !start_det && active_q) && !ev_step) |=> $stable(wiper_bus));

    // R8: an upward step below the top moves the position by exactly one.
    p_step_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_step && step_up && (wiper_q[ch_q][POS_W-1:0] != '1))
        |=> (wiper_q[ch_q][POS_W-1:0] == $past(wiper_q[ch_q][POS_W-1:0]) + POS_W'(1)));

endmodule

// File: tb/pot_cmd_engine_test.sv
// Bench: directed command sequences plus a behavioural reference model
// compared against every output on each falling clock edge.
module pot_cmd_engine_test;

    localparam int BUSY = 37;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_det = 1'b0, stop_det = 1'b0;
    logic        instr_valid = 1'b0, data_valid = 1'b0;
    logic        step_valid = 1'b0, step_up = 1'b0;
    logic [7:0]  instr_byte = '0, data_byte = '0;
    logic        data_phase, step_mode, busy;
    logic [7:0]  rd_data;
    logic [31:0] wiper_bus;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_en = 1'b0;

    always #2.5 clk = ~clk;

    pot_cmd_engine #(.BUSY_CYCLES(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
        .instr_valid(instr_valid), .instr_byte(instr_byte),
        .data_valid(data_valid), .data_byte(data_byte),
        .step_valid(step_valid), .step_up(step_up),
        .data_phase(data_phase), .step_mode(step_mode), .busy(busy),
        .rd_data(rd_data), .wiper_bus(wiper_bus)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model state.
    int m_w[4];
    int m_dr[16];
    int m_busy, m_op, m_ch, m_rs, m_data, m_rd;
    bit m_act, m_got;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_w[i]) m_w[i] = 0;
            foreach (m_dr[i]) m_dr[i] = 0;
            m_busy = 0; m_op = 0; m_ch = 0; m_rs = 0; m_data = 0; m_rd = 0;
            m_act = 0; m_got = 0;
        end else begin
            bit was_busy;
            bit nv;
            was_busy = (m_busy > 0);
            nv = 0;
            if (start_det) begin
                m_act = 0;
            end else if (stop_det) begin
                if (m_act) begin
                    case (m_op)
                        10: if (m_got) m_w[m_ch] = m_data;
                        12: if (m_got) begin m_dr[m_ch*4+m_rs] = m_data; nv = 1; end
                        13: m_w[m_ch] = m_dr[m_ch*4+m_rs];
                        14: begin m_dr[m_ch*4+m_rs] = m_w[m_ch]; nv = 1; end
                        1:  for (int c = 0; c < 4; c++) m_w[c] = m_dr[c*4+m_rs];
                        8:  begin for (int c = 0; c < 4; c++) m_dr[c*4+m_rs] = m_w[c]; nv = 1; end
                        default: ;
                    endcase
                end
                m_act = 0;
            end else if (instr_valid) begin
                if (!was_busy) begin
                    m_op = instr_byte[7:4]; m_ch = instr_byte[3:2]; m_rs = instr_byte[1:0];
                    m_act = 1; m_got = 0;
                    if (m_op == 9)  m_rd = m_w[m_ch];
                    if (m_op == 11) m_rd = m_dr[m_ch*4+m_rs];
                end
            end else if (data_valid && m_act && (m_op == 10 || m_op == 12)) begin
                m_data = data_byte; m_got = 1;
            end else if (step_valid && m_act && m_op == 2) begin
                int p;
                p = m_w[m_ch] % 64;
                if (step_up && p < 63) p++;
                else if (!step_up && p > 0) p--;
                m_w[m_ch] = (m_w[m_ch] / 64) * 64 + p;
            end
            if (nv) m_busy = BUSY;
            else if (was_busy) m_busy = m_busy - 1;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R4 wipers vs model", wiper_bus,
                {m_w[3][7:0], m_w[2][7:0], m_w[1][7:0], m_w[0][7:0]});
            chk("R3 rd_data vs model", {24'd0, rd_data}, m_rd);
            chk("R10 busy vs model", {31'd0, busy}, {31'd0, m_busy > 0});
            chk("R9 data_phase vs model", {31'd0, data_phase},
                {31'd0, m_act && (m_op >= 9 && m_op <= 12)});
            chk("R9 step_mode vs model", {31'd0, step_mode}, {31'd0, m_act && m_op == 2});
        end
    end

    task automatic p_instr(input logic [7:0] b);
        @(negedge clk); instr_valid = 1'b1; instr_byte = b;
        @(negedge clk); instr_valid = 1'b0;
    endtask
    task automatic p_data(input logic [7:0] b);
        @(negedge clk); data_valid = 1'b1; data_byte = b;
        @(negedge clk); data_valid = 1'b0;
    endtask
    task automatic p_stop();
        @(negedge clk); stop_det = 1'b1;
        @(negedge clk); stop_det = 1'b0;
    endtask
    task automatic p_start();
        @(negedge clk); start_det = 1'b1;
        @(negedge clk); start_det = 1'b0;
    endtask
    task automatic p_step(input logic up);
        @(negedge clk); step_valid = 1'b1; step_up = up;
        @(negedge clk); step_valid = 1'b0;
    endtask
    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    function automatic logic [7:0] wip(input int c);
        return wiper_bus[c*8 +: 8];
    endfunction

    function void summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1;
        // R1 reset state
        chk("R1 wipers", wiper_bus, 32'h0);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 data_phase", {31'd0, data_phase}, 32'd0);
        chk("R1 step_mode", {31'd0, step_mode}, 32'd0);
        chk("R1 rd_data", {24'd0, rd_data}, 32'd0);

        // R4 write wiper ch2
        p_instr(8'hA8);
        chk("R9 data_phase after write-wiper", {31'd0, data_phase}, 32'd1);
        p_data(8'h6A);
        chk("R4 no change before stop", {24'd0, wip(2)}, 32'h00);
        p_stop();
        chk("R4 wiper2 written", {24'd0, wip(2)}, 32'h6A);

        // R3 R2 read wiper ignores register bits
        p_instr(8'h9B);
        chk("R3 R2 read wiper ch2", {24'd0, rd_data}, 32'h6A);
        p_stop();

        // R5 write stored register ch1 r2
        p_instr(8'hC6); p_data(8'h15); p_stop();
        chk("R5 busy after stored write", {31'd0, busy}, 32'd1);
        // R10 instruction ignored while busy
        p_instr(8'hA4);
        chk("R10 ignored instr no phase", {31'd0, data_phase}, 32'd0);
        p_data(8'h3F); p_stop();
        chk("R10 ignored write leaves wiper1", {24'd0, wip(1)}, 32'h00);
        wait_idle();

        p_instr(8'hB6);
        chk("R3 read stored ch1 r2", {24'd0, rd_data}, 32'h15);
        p_stop();
        p_instr(8'hB9);
        chk("R2 register field distinct", {24'd0, rd_data}, 32'h00);
        p_stop();

        // R6 load one
        p_instr(8'hD6);
        chk("R9 no phase for transfer", {31'd0, data_phase}, 32'd0);
        p_stop();
        chk("R6 load ch1 from r2", {24'd0, wip(1)}, 32'h15);
        chk("R6 load is not a nv write", {31'd0, busy}, 32'd0);

        // R6 store one, R10 window length
        p_instr(8'hE9); p_stop();
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk("R10 busy window length", n, BUSY);
        p_instr(8'hB9);
        chk("R6 stored ch2 r1", {24'd0, rd_data}, 32'h6A);
        p_stop();

        // R7 global store then global load, channel bits ignored
        p_instr(8'hAC); p_data(8'hC5); p_stop();
        p_instr(8'h8F); p_stop();
        chk("R7 global store busy", {31'd0, busy}, 32'd1);
        wait_idle();
        p_instr(8'hA0); p_data(8'h01); p_stop();
        p_instr(8'hA8); p_data(8'h00); p_stop();
        p_instr(8'h1F); p_stop();
        chk("R7 global load", wiper_bus, 32'hC56A1500);
        p_instr(8'hB7);
        chk("R7 stored ch1 r3", {24'd0, rd_data}, 32'h15);
        p_stop();

        // R8 stepping
        p_step(1'b1);
        chk("R8 step outside mode ignored", wiper_bus, 32'hC56A1500);
        p_instr(8'h24);
        chk("R9 step_mode", {31'd0, step_mode}, 32'd1);
        p_step(1'b1); p_step(1'b1); p_step(1'b1);
        chk("R8 step up three", {24'd0, wip(1)}, 32'h18);
        p_stop();
        chk("R9 step_mode cleared", {31'd0, step_mode}, 32'd0);
        p_instr(8'h2C);
        for (int i = 0; i < 7; i++) p_step(1'b0);
        chk("R8 saturate at bottom", {24'd0, wip(3)}, 32'hC0);
        p_stop();
        p_instr(8'hA0); p_data(8'h3E); p_stop();
        p_instr(8'h20);
        for (int i = 0; i < 3; i++) p_step(1'b1);
        chk("R8 saturate at top", {24'd0, wip(0)}, 32'h3F);
        p_stop();

        // R11 undefined opcodes
        p_instr(8'h55);
        chk("R11 no phase", {30'd0, data_phase, step_mode}, 32'd0);
        p_data(8'h77); p_stop();
        chk("R11 wipers unchanged", wiper_bus, 32'hC06A183F);
        chk("R11 no busy", {31'd0, busy}, 32'd0);
        p_instr(8'hF3); p_stop();
        chk("R11 opcode 1111 no effect", wiper_bus, 32'hC06A183F);

        // R12 start discards
        p_instr(8'hA0); p_data(8'h22); p_start();
        chk("R12 wiper write discarded", {24'd0, wip(0)}, 32'h3F);
        p_instr(8'hC0); p_data(8'h99); p_start();
        p_stop();
        chk("R12 no busy after discard", {31'd0, busy}, 32'd0);
        p_instr(8'hB0);
        chk("R12 stored ch0 r0 unchanged", {24'd0, rd_data}, 32'h00);
        p_stop();

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule